// File: doc/BRIEF.md
# Vector Element Address Generator

This block turns one vector memory instruction's operands into a stream of effective addresses, one per element. A start pulse captures a base value, a flag that forces the base to zero, a 16-bit signed displacement, an access size in bytes, an element count, an addressing mode and a shift amount. The block then steps an element index upward from zero. For each element it presents the address, the index and a last-element marker on a valid/ready handshake.

Three addressing modes share the one index counter. Unit stride places consecutive elements one access size apart after the displacement. Element stride uses the displacement itself as the step. Bit-reversed mode scales the displacement by the access size and by the bit-reversed index, then shifts the product left. This gives the reordering used by in-place radix-2 FFT passes.

The controller has four states. IDLE waits for start. STREAM presents elements. DONE is a one-cycle completion marker. FAULT is a one-cycle rejection marker. The transitions are as follows. IDLE goes to STREAM on start with a legal, non-zero count. IDLE goes to DONE on start with a zero count. IDLE goes to FAULT on start with an illegal count. STREAM goes to DONE when the last element is accepted. DONE returns to IDLE and FAULT returns to IDLE after one cycle.

Top module: `vagen_top`

## Requirements
- R1: When the base-zero flag is 1 at start, every address uses a base of 0, whatever the base value.
- R2: With mode code 00 (unit stride), element i has address base + sext(disp) + size*i. Mode code 11 behaves the same way.
- R3: With mode code 01 (element stride) and a non-zero displacement, element i has address base + sext(disp)*i. With a zero displacement, mode 01 behaves as unit stride.
- R4: With mode code 10 (bit-reversed), element i has address base + ((sext(disp)*size*rev(i)) << shift). Here rev(i) reverses the low log2(VL) bits of i, so for VL=4 the indices 0,1,2,3 map to 0,2,1,3.
- R5: A start is rejected when VL exceeds 64 in any mode, or when mode 10 has a non-zero VL that is not a power of two. In that case err_o is 1 for exactly the cycle after the start, and no element is presented.
- R6: A start with VL=0 produces no elements. done_o is 1 for exactly the cycle after the start.
- R7: After an accepted start, addr_valid_o rises in the next cycle with index 0. The index advances by one only on a cycle where addr_valid_o and addr_ready_i are both 1. While a stall lasts, the address and the index hold.
- R8: last_o is 1 exactly while index VL-1 is presented. In the cycle after that element is accepted, done_o is 1 and addr_valid_o is 0. The cycle after that, busy_o is 0.
- R9: A start pulse that arrives while busy_o is 1 is ignored.
- R10: The displacement is sign-extended to 64 bits, and all address arithmetic wraps modulo 2^64.
- R11: During reset, addr_valid_o, done_o, err_o and busy_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture operands and begin a sequence (only in IDLE) |
| base_i | input | 64 | Base register value |
| base_zero_i | input | 1 | Force the base to zero |
| disp_i | input | 16 | Signed displacement |
| size_i | input | 4 | Access size in bytes |
| vl_i | input | 7 | Number of elements (0 to 64) |
| mode_i | input | 2 | 00 unit, 01 element stride, 10 bit-reversed, 11 as unit |
| shift_i | input | 6 | Left shift for bit-reversed mode |
| addr_ready_i | input | 1 | Consumer accepts the presented element |
| addr_valid_o | output | 1 | An element address is presented |
| addr_o | output | 64 | Effective address of the presented element |
| idx_o | output | 6 | Index of the presented element |
| last_o | output | 1 | The presented element is the final one |
| done_o | output | 1 | One-cycle completion marker |
| err_o | output | 1 | One-cycle rejection marker |
| busy_o | output | 1 | Controller is not idle |

## Verification
Two things can meet in one cycle: acceptance of the final element, and a new start pulse. The bench raises start_i with fresh operands on the same edge that the last element is handshaken. It then checks that the next cycle shows only the completion marker and that no new stream follows, so the late start has no effect. Stalls placed on the final element and on middle elements check that the last marker and the address hold until acceptance.

// File: rtl/vagen_pkg.sv
package vagen_pkg;
    typedef enum logic [1:0] {
        AM_UNIT = 2'b00,
        AM_ELEM = 2'b01,
        AM_BREV = 2'b10,
        AM_RSVD = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_DONE,
        ST_FAULT
    } state_e;
endpackage

// File: rtl/vagen_legal.sv
module vagen_legal #(
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int LG_W  = $clog2(IDX_W + 1)
) (
    input  logic [VL_W-1:0]  vl,
    input  vagen_pkg::amode_e mode,
    output logic             vl_zero,
    output logic             illegal,
    output logic [LG_W-1:0]  lg
);
    logic pow2;
    logic too_big;

    always_comb begin
        pow2 = 1'b0;
        lg   = '0;
        for (int k = 0; k <= IDX_W; k++) begin
            if (vl == VL_W'(1 << k)) begin
                pow2 = 1'b1;
                lg   = LG_W'(k);
            end
        end
    end

    assign vl_zero = (vl == '0);
    assign too_big = (vl > VL_W'(MAX_VL));
    assign illegal = too_big || ((mode == vagen_pkg::AM_BREV) && !pow2);
endmodule

// File: rtl/vagen_bitrev.sv
module vagen_bitrev #(
    parameter int IDX_W = 6,
    localparam int LG_W = $clog2(IDX_W + 1)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [LG_W-1:0]  lg,
    output logic [IDX_W-1:0] rev
);
    logic [IDX_W-1:0] mirrored;

    for (genvar g = 0; g < IDX_W; g++) begin : g_mirror
        assign mirrored[g] = idx[IDX_W-1-g];
    end

    assign rev = mirrored >> (LG_W'(IDX_W) - lg);
endmodule

// File: rtl/vagen_addr_calc.sv
module vagen_addr_calc #(
    parameter int ADDR_W  = 64,
    parameter int DISP_W  = 16,
    parameter int SIZE_W  = 4,
    parameter int SHIFT_W = 6,
    parameter int IDX_W   = 6
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [DISP_W-1:0]  disp,
    input  logic [SIZE_W-1:0]  size,
    input  vagen_pkg::amode_e  mode,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [IDX_W-1:0]   idx,
    input  logic [IDX_W-1:0]   rev,
    output logic [ADDR_W-1:0]  addr
);
    import vagen_pkg::*;

    logic [ADDR_W-1:0] dext;
    logic [ADDR_W-1:0] size_w;
    logic [ADDR_W-1:0] idx_w;
    logic [ADDR_W-1:0] rev_w;
    logic [ADDR_W-1:0] off_unit;
    logic [ADDR_W-1:0] off_elem;
    logic [ADDR_W-1:0] off_brev;
    logic              elem_on;

    assign dext     = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    assign size_w   = ADDR_W'(size);
    assign idx_w    = ADDR_W'(idx);
    assign rev_w    = ADDR_W'(rev);
    assign off_unit = dext + size_w * idx_w;
    assign off_elem = dext * idx_w;
    assign off_brev = (dext * size_w * rev_w) << shift;
    assign elem_on  = (disp != '0);

    always_comb begin
        unique case (mode)
            AM_ELEM: addr = base + (elem_on ? off_elem : off_unit);
            AM_BREV: addr = base + off_brev;
            AM_UNIT,
            AM_RSVD: addr = base + off_unit;
            default: addr = base + off_unit;
        endcase
    end
endmodule

// File: rtl/vagen_fsm.sv
module vagen_fsm #(
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             vl_zero,
    input  logic             illegal,
    input  logic [VL_W-1:0]  vl,
    input  logic             ready,
    output logic             load,
    output logic [IDX_W-1:0] idx,
    output logic             valid,
    output logic             last,
    output logic             done,
    output logic             err,
    output logic             busy
);
    import vagen_pkg::*;

    state_e           state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [VL_W-1:0]  vl_q;
    logic             accept;

    assign load   = (state_q == ST_IDLE) && start;
    assign accept = valid && ready;
    assign last   = (state_q == ST_STREAM) && ({1'b0, idx_q} == vl_q - VL_W'(1));
    assign idx    = idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (vl_zero)      state_d = ST_DONE;
                    else if (illegal) state_d = ST_FAULT;
                    else              state_d = ST_STREAM;
                end
            end
            ST_STREAM: if (accept && last) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            vl_q    <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                idx_q <= '0;
                vl_q  <= vl;
            end else if (accept && !last) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        valid = 1'b0;
        done  = 1'b0;
        err   = 1'b0;
        busy  = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy  = 1'b0;
            ST_STREAM: valid = 1'b1;
            ST_DONE:   done  = 1'b1;
            ST_FAULT:  err   = 1'b1;
            default:   busy  = 1'b0;
        endcase
    end
endmodule

// File: rtl/vagen_top.sv
module vagen_top #(
    parameter int ADDR_W  = 64,
    parameter int DISP_W  = 16,
    parameter int SIZE_W  = 4,
    parameter int SHIFT_W = 6,
    parameter int MAX_VL  = 64,
    localparam int IDX_W  = $clog2(MAX_VL),
    localparam int VL_W   = $clog2(MAX_VL + 1),
    localparam int LG_W   = $clog2(IDX_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic               base_zero_i,
    input  logic [DISP_W-1:0]  disp_i,
    input  logic [SIZE_W-1:0]  size_i,
    input  logic [VL_W-1:0]    vl_i,
    input  logic [1:0]         mode_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               addr_ready_i,
    output logic               addr_valid_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               last_o,
    output logic               done_o,
    output logic               err_o,
    output logic               busy_o
);
    import vagen_pkg::*;

    amode_e             mode_in;
    amode_e             mode_q;
    logic [ADDR_W-1:0]  base_q;
    logic [DISP_W-1:0]  disp_q;
    logic [SIZE_W-1:0]  size_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [LG_W-1:0]    lg_in, lg_q;
    logic               vl_zero, illegal, load;
    logic [IDX_W-1:0]   idx, rev;

    assign mode_in = amode_e'(mode_i);

    vagen_legal #(.MAX_VL(MAX_VL)) u_legal (
        .vl      (vl_i),
        .mode    (mode_in),
        .vl_zero (vl_zero),
        .illegal (illegal),
        .lg      (lg_in)
    );

    vagen_fsm #(.MAX_VL(MAX_VL)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .vl_zero (vl_zero),
        .illegal (illegal),
        .vl      (vl_i),
        .ready   (addr_ready_i),
        .load    (load),
        .idx     (idx),
        .valid   (addr_valid_o),
        .last    (last_o),
        .done    (done_o),
        .err     (err_o),
        .busy    (busy_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            disp_q  <= '0;
            size_q  <= '0;
            shift_q <= '0;
            mode_q  <= AM_UNIT;
            lg_q    <= '0;
        end else if (load) begin
            base_q  <= base_zero_i ? '0 : base_i;
            disp_q  <= disp_i;
            size_q  <= size_i;
            shift_q <= shift_i;
            mode_q  <= mode_in;
            lg_q    <= lg_in;
        end
    end

    vagen_bitrev #(.IDX_W(IDX_W)) u_rev (
        .idx (idx),
        .lg  (lg_q),
        .rev (rev)
    );

    vagen_addr_calc #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .SIZE_W (SIZE_W),
        .SHIFT_W(SHIFT_W),
        .IDX_W  (IDX_W)
    ) u_calc (
        .base  (base_q),
        .disp  (disp_q),
        .size  (size_q),
        .mode  (mode_q),
        .shift (shift_q),
        .idx   (idx),
        .rev   (rev),
        .addr  (addr_o)
    );

    assign idx_o = idx;
endmodule

// File: rtl/vagen_checker.sv
module vagen_checker #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              addr_ready_i,
    input logic              addr_valid_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [IDX_W-1:0]  idx_o,
    input logic              last_o,
    input logic              done_o,
    input logic              err_o,
    input logic              busy_o
);
    AST_FIRST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid_o) |-> (idx_o == '0)); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && !addr_ready_i) |=> (addr_valid_o && $stable(addr_o) && $stable(idx_o) && $stable(last_o))); // R7

    AST_IDX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && addr_ready_i && !last_o) |=> (addr_valid_o && idx_o == $past(idx_o) + IDX_W'(1))); // R7

    AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && addr_ready_i && last_o) |=> (done_o && !addr_valid_o)); // R8

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !addr_valid_o)); // R8

    AST_FAULT_NO_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!addr_valid_o && !err_o)); // R5

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && addr_valid_o && !(addr_ready_i && last_o)) |=> addr_valid_o); // R9

    AST_MARKERS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o) && !(last_o && !addr_valid_o)); // R8
endmodule

bind vagen_top vagen_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .addr_ready_i (addr_ready_i),
    .addr_valid_o (addr_valid_o),
    .addr_o       (addr_o),
    .idx_o        (idx_o),
    .last_o       (last_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .busy_o       (busy_o)
);

// File: tb/vagen_top_test.sv
module vagen_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] base_i = '0;
    logic        base_zero_i = 1'b0;
    logic [15:0] disp_i = '0;
    logic [3:0]  size_i = '0;
    logic [6:0]  vl_i = '0;
    logic [1:0]  mode_i = '0;
    logic [5:0]  shift_i = '0;
    logic        addr_ready_i = 1'b0;
    logic        addr_valid_o;
    logic [63:0] addr_o;
    logic [5:0]  idx_o;
    logic        last_o, done_o, err_o, busy_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vagen_top uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .base_zero_i(base_zero_i), .disp_i(disp_i), .size_i(size_i),
        .vl_i(vl_i), .mode_i(mode_i), .shift_i(shift_i),
        .addr_ready_i(addr_ready_i), .addr_valid_o(addr_valid_o),
        .addr_o(addr_o), .idx_o(idx_o), .last_o(last_o),
        .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [63:0] model(input logic [63:0] b, input logic bz,
            input logic [15:0] d, input logic [3:0] sz, input int vl,
            input logic [1:0] md, input logic [5:0] sh, input int i);
        logic [63:0] bb, dd, r;
        int lg;
        bb = bz ? 64'd0 : b;
        dd = 64'($signed(d));
        if (md == 2'b01 && d != 16'd0) return bb + dd * 64'(i);
        if (md == 2'b10) begin
            lg = 0;
            while ((1 << lg) < vl) lg++;
            r = '0;
            for (int k = 0; k < lg; k++)
                if (((i >> k) & 1) == 1) r = r | (64'd1 << (lg - 1 - k));
            return bb + ((dd * 64'(sz) * r) << sh);
        end
        return bb + dd + 64'(sz) * 64'(i);
    endfunction

    task automatic launch(input logic [63:0] b, input logic bz, input logic [15:0] d,
            input logic [3:0] sz, input logic [6:0] vl, input logic [1:0] md, input logic [5:0] sh);
        @(negedge clk);
        base_i = b; base_zero_i = bz; disp_i = d; size_i = sz;
        vl_i = vl; mode_i = md; shift_i = sh; start_i = 1'b1; addr_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic check_elem(input string req, input logic [63:0] b, input logic bz,
            input logic [15:0] d, input logic [3:0] sz, input int vl, input logic [1:0] md,
            input logic [5:0] sh, input int i);
        chk({req, " valid"}, 64'(addr_valid_o), 64'd1);
        chk({req, " R7 idx"}, 64'(idx_o), 64'(i));
        chk({req, " addr"}, addr_o, model(b, bz, d, sz, vl, md, sh, i));
        chk({req, " R8 last"}, 64'(last_o), 64'(i == vl - 1));
    endtask

    task automatic run_stream(input string req, input logic [63:0] b, input logic bz,
            input logic [15:0] d, input logic [3:0] sz, input logic [6:0] vl,
            input logic [1:0] md, input logic [5:0] sh, input int stall_at, input bit collide);
        launch(b, bz, d, sz, vl, md, sh);
        for (int i = 0; i < int'(vl); i++) begin
            if (i == stall_at) begin
                check_elem(req, b, bz, d, sz, vl, md, sh, i);
                @(negedge clk);
            end
            check_elem(req, b, bz, d, sz, vl, md, sh, i);
            addr_ready_i = 1'b1;
            if (collide && i == int'(vl) - 1) begin
                base_i = 64'h7000; vl_i = 7'd3; mode_i = 2'b00; start_i = 1'b1;
            end
            @(negedge clk);
            addr_ready_i = 1'b0;
            start_i = 1'b0;
        end
        chk({req, " R8 done"}, 64'(done_o), 64'd1);
        chk({req, " R8 valid after last"}, 64'(addr_valid_o), 64'd0);
        @(negedge clk);
        chk({req, " R8 busy idle"}, 64'(busy_o), 64'd0);
        chk({req, " R9 no restart"}, 64'(addr_valid_o), 64'd0);
    endtask

    task automatic test_reset();
        chk("R11 valid", 64'(addr_valid_o), 64'd0);
        chk("R11 done", 64'(done_o), 64'd0);
        chk("R11 err", 64'(err_o), 64'd0);
        chk("R11 busy", 64'(busy_o), 64'd0);
    endtask

    task automatic test_reject(input string req, input logic [6:0] vl, input logic [1:0] md);
        launch(64'h100, 1'b0, 16'd4, 4'd4, vl, md, 6'd0);
        chk({req, " err pulse"}, 64'(err_o), 64'd1);
        chk({req, " no valid"}, 64'(addr_valid_o), 64'd0);
        @(negedge clk);
        chk({req, " err cleared"}, 64'(err_o), 64'd0);
        chk({req, " still no valid"}, 64'(addr_valid_o), 64'd0);
        chk({req, " idle"}, 64'(busy_o), 64'd0);
    endtask

    task automatic test_zero_vl();
        launch(64'h100, 1'b0, 16'd4, 4'd4, 7'd0, 2'b10, 6'd0);
        chk("R6 done pulse", 64'(done_o), 64'd1);
        chk("R6 no valid", 64'(addr_valid_o), 64'd0);
        chk("R6 no err", 64'(err_o), 64'd0);
        @(negedge clk);
        chk("R6 done cleared", 64'(done_o), 64'd0);
        chk("R6 idle", 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        // R2 unit stride with a stall on element 2
        run_stream("R2 unit", 64'h1000, 1'b0, 16'd8, 4'd4, 7'd5, 2'b00, 6'd0, 2, 1'b0);
        // R2 reserved code as unit stride
        run_stream("R2 reserved", 64'h200, 1'b0, 16'd16, 4'd8, 7'd3, 2'b11, 6'd0, -1, 1'b0);
        // R10 negative displacement wraps below zero
        run_stream("R10 wrap", 64'h4, 1'b0, 16'hFFE0, 4'd2, 7'd4, 2'b00, 6'd0, -1, 1'b0);
        // R3 element stride: 0x10, 0x28
        run_stream("R3 elem", 64'h10, 1'b0, 16'd24, 4'd4, 7'd2, 2'b01, 6'd0, 1, 1'b0);
        // R3 zero displacement falls back to unit stride
        run_stream("R3 elem zero disp", 64'h100, 1'b0, 16'd0, 4'd4, 7'd3, 2'b01, 6'd0, -1, 1'b0);
        // R4 bit-reversed VL=4: 0x10, 0x18, 0x14, 0x1c
        run_stream("R4 brev4", 64'h10, 1'b0, 16'd1, 4'd4, 7'd4, 2'b10, 6'd0, -1, 1'b0);
        run_stream("R4 brev8 shift", 64'h4000, 1'b0, 16'd3, 4'd2, 7'd8, 2'b10, 6'd2, 5, 1'b0);
        run_stream("R4 brev1", 64'h40, 1'b0, 16'd7, 4'd4, 7'd1, 2'b10, 6'd1, -1, 1'b0);
        run_stream("R4 brev64", 64'h0, 1'b0, 16'd1, 4'd1, 7'd64, 2'b10, 6'd0, 63, 1'b0);
        // R1 base forced to zero
        run_stream("R1 base zero", 64'hDEAD_BEEF_0000_1000, 1'b1, 16'd12, 4'd4, 7'd3, 2'b00, 6'd0, -1, 1'b0);
        // R9 start arriving with the final acceptance, stall on last
        run_stream("R9 collide", 64'h800, 1'b0, 16'd0, 4'd8, 7'd3, 2'b00, 6'd0, 2, 1'b1);
        // R5 rejections
        test_reject("R5 brev non-pow2", 7'd6, 2'b10);
        test_reject("R5 vl above max", 7'd65, 2'b00);
        // R6 zero length
        test_zero_vl();
        repeat (2) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule